// File: doc/BRIEF.md
# Address-Window Bus Splitter

This block sits between one AXI4-Lite requester and several downstream register ports. Each port owns one aligned address window whose size is a power of two. The windows are fixed by parameters. The block decodes the write and read addresses and steers the valid strobes only to the port whose window matches. It presents that port with the offset inside its window, and returns the port's ready and response signals to the requester. Decoding and steering are combinational, so a forwarded request appears in the same cycle it is presented.

Two kinds of request are answered inside the block and never reach a port. The first is an address that falls in no window. The second is a write address that arrives without its write data in the same cycle. In both cases the block raises a registered error response (SLVERR, code 2) one cycle later. It holds that response until the requester takes it.

Each direction allows one transaction in flight. After a request is accepted, a small owner register records which port must answer. No further request in that direction is taken until the response handshake completes.

Top module: `axil_window_split`

## Requirements
- R1: At most one port sees its write-address/write-data valid, or its read-address valid, in any cycle. It is the port whose window holds the address. Every other port sees these valids low.
- R2: A write is forwarded only when the write-address valid and the write-data valid are both high in the same cycle, the address is mapped, and no write response is pending. The upstream AWREADY and WREADY are high together, and only in a cycle where both valids are high. For a mapped write they equal the selected port's AWREADY AND WREADY.
- R3: A write-address valid with the write-data valid low forwards nothing and keeps AWREADY and WREADY low. In the next cycle the block returns BVALID=1 with BRESP=2.
- R4: A read to an address outside every window raises no port's ARVALID. ARREADY is high in the request cycle. In the next cycle RVALID=1, RRESP=2 and RDATA=0.
- R5: A write to an address outside every window, with both valids high, forwards no valid. AWREADY and WREADY are high in the request cycle, and in the next cycle BVALID=1 with BRESP=2.
- R6: The write data and byte strobes reach the selected port unchanged.
- R7: After a forwarded write is accepted, BVALID and BRESP come from the port that took it, so a port answering 0 (OKAY) yields BRESP=0. Only that port sees BREADY.
- R8: Upstream ARREADY equals the selected port's ARREADY. After a read is accepted, RVALID, RDATA and RRESP come from the port that took it, and only that port sees RREADY.
- R9: The address given to a port is the upstream address minus that port's window base.
- R10: A local error response stays valid until its ready is high at a clock edge, and is low after that edge. While any write or read response is pending in a direction, no new request in that direction is forwarded or accepted.
- R11: During and right after synchronous active-high reset, with idle inputs, every valid and ready output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| s_awvalid | input | 1 | Upstream write-address valid |
| s_awaddr | input | ADDR_W | Upstream write address |
| s_awready | output | 1 | Upstream write-address ready |
| s_wvalid | input | 1 | Upstream write-data valid |
| s_wdata | input | DATA_W | Upstream write data |
| s_wstrb | input | DATA_W/8 | Upstream byte strobes |
| s_wready | output | 1 | Upstream write-data ready |
| s_bvalid | output | 1 | Upstream write-response valid |
| s_bresp | output | 2 | Upstream write-response code |
| s_bready | input | 1 | Upstream write-response ready |
| s_arvalid | input | 1 | Upstream read-address valid |
| s_araddr | input | ADDR_W | Upstream read address |
| s_arready | output | 1 | Upstream read-address ready |
| s_rvalid | output | 1 | Upstream read-data valid |
| s_rdata | output | DATA_W | Upstream read data |
| s_rresp | output | 2 | Upstream read-response code |
| s_rready | input | 1 | Upstream read-data ready |
| m_awvalid | output | N_PORT | Per-port write-address valid |
| m_awaddr | output | N_PORT*ADDR_W | Per-port rebased write address |
| m_awready | input | N_PORT | Per-port write-address ready |
| m_wvalid | output | N_PORT | Per-port write-data valid |
| m_wdata | output | N_PORT*DATA_W | Per-port write data |
| m_wstrb | output | N_PORT*DATA_W/8 | Per-port byte strobes |
| m_wready | input | N_PORT | Per-port write-data ready |
| m_bvalid | input | N_PORT | Per-port write-response valid |
| m_bresp | input | N_PORT*2 | Per-port write-response code |
| m_bready | output | N_PORT | Per-port write-response ready |
| m_arvalid | output | N_PORT | Per-port read-address valid |
| m_araddr | output | N_PORT*ADDR_W | Per-port rebased read address |
| m_arready | input | N_PORT | Per-port read-address ready |
| m_rvalid | input | N_PORT | Per-port read-data valid |
| m_rdata | input | N_PORT*DATA_W | Per-port read data |
| m_rresp | input | N_PORT*2 | Per-port read-response code |
| m_rready | output | N_PORT | Per-port read-data ready |

## Verification
Forwarded valids, rebased addresses, write data and upstream readies are due in the same cycle the request is driven. A port's response shows upstream in any cycle after the accepting edge in which that port drives it. Local error responses are due exactly one edge after the offending request and drop one edge after the ready handshake. The bench drives inputs at the falling edge and compares every output a little later in the same low phase. It compares against a behavioural model whose owner and error state advance only at the rising edge. A result that comes one cycle early or late therefore shows up as a mismatch in that cycle.

// File: rtl/split_pkg.sv
`timescale 1ns/1ps
package split_pkg;
  typedef logic [1:0] resp_t;
  localparam resp_t RESP_OKAY   = 2'b00;
  localparam resp_t RESP_SLVERR = 2'b10;
endpackage

// File: rtl/split_addr_decode.sv
`timescale 1ns/1ps
// Window match and offset extraction for one address channel.
module split_addr_decode #(
  parameter int N_PORT = 3,
  parameter int ADDR_W = 16,
  parameter int IW     = 2,
  parameter logic [N_PORT*ADDR_W-1:0] WIN_BASE = '0,
  parameter logic [N_PORT*8-1:0]      WIN_LOG2 = '0
) (
  input  logic [ADDR_W-1:0]        addr,
  output logic [N_PORT-1:0]        hit,
  output logic [IW-1:0]            idx,
  output logic [N_PORT*ADDR_W-1:0] offset
);
  for (genvar g = 0; g < N_PORT; g++) begin : g_win
    localparam int              L    = int'(WIN_LOG2[g*8 +: 8]);
    localparam logic [ADDR_W-1:0] BASE = WIN_BASE[g*ADDR_W +: ADDR_W];
    localparam logic [ADDR_W-1:0] MASK = (ADDR_W'(1) << L) - ADDR_W'(1);
    assign hit[g] = ((addr ^ BASE) & ~MASK) == '0;
    assign offset[g*ADDR_W +: ADDR_W] = addr & MASK;
  end

  always_comb begin
    idx = '0;
    for (int i = 0; i < N_PORT; i++) begin
      if (hit[i]) idx = IW'(i);
    end
  end
endmodule

// File: rtl/split_err_resp.sv
`timescale 1ns/1ps
// Registered local error response: set by start, held until ready.
module split_err_resp (
  input  logic clk,
  input  logic rst,
  input  logic start,
  input  logic ready,
  output logic valid
);
  always_ff @(posedge clk) begin
    if (rst)        valid <= 1'b0;
    else if (start) valid <= 1'b1;
    else if (ready) valid <= 1'b0;
  end

  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    valid && !ready |=> valid); // R10
  AST_ERR_DONE: assert property (@(posedge clk) disable iff (rst)
    valid && ready |=> !valid); // R10
endmodule

// File: rtl/axil_window_split.sv
`timescale 1ns/1ps
module axil_window_split
  import split_pkg::*;
#(
  parameter int N_PORT = 3,
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter logic [N_PORT*ADDR_W-1:0] WIN_BASE = {16'h4000, 16'h1000, 16'h0000},
  parameter logic [N_PORT*8-1:0]      WIN_LOG2 = {8'd13, 8'd12, 8'd12}
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         s_awvalid,
  input  logic [ADDR_W-1:0]            s_awaddr,
  output logic                         s_awready,
  input  logic                         s_wvalid,
  input  logic [DATA_W-1:0]            s_wdata,
  input  logic [DATA_W/8-1:0]          s_wstrb,
  output logic                         s_wready,
  output logic                         s_bvalid,
  output logic [1:0]                   s_bresp,
  input  logic                         s_bready,
  input  logic                         s_arvalid,
  input  logic [ADDR_W-1:0]            s_araddr,
  output logic                         s_arready,
  output logic                         s_rvalid,
  output logic [DATA_W-1:0]            s_rdata,
  output logic [1:0]                   s_rresp,
  input  logic                         s_rready,
  output logic [N_PORT-1:0]            m_awvalid,
  output logic [N_PORT*ADDR_W-1:0]     m_awaddr,
  input  logic [N_PORT-1:0]            m_awready,
  output logic [N_PORT-1:0]            m_wvalid,
  output logic [N_PORT*DATA_W-1:0]     m_wdata,
  output logic [N_PORT*DATA_W/8-1:0]   m_wstrb,
  input  logic [N_PORT-1:0]            m_wready,
  input  logic [N_PORT-1:0]            m_bvalid,
  input  logic [N_PORT*2-1:0]          m_bresp,
  output logic [N_PORT-1:0]            m_bready,
  output logic [N_PORT-1:0]            m_arvalid,
  output logic [N_PORT*ADDR_W-1:0]     m_araddr,
  input  logic [N_PORT-1:0]            m_arready,
  input  logic [N_PORT-1:0]            m_rvalid,
  input  logic [N_PORT*DATA_W-1:0]     m_rdata,
  input  logic [N_PORT*2-1:0]          m_rresp,
  output logic [N_PORT-1:0]            m_rready
);
  localparam int STRB_W = DATA_W / 8;
  localparam int IW     = (N_PORT > 1) ? $clog2(N_PORT) : 1;

  logic [N_PORT-1:0]        aw_hit, ar_hit;
  logic [IW-1:0]            aw_idx, ar_idx;
  logic [N_PORT*ADDR_W-1:0] aw_off, ar_off;

  logic          w_pend, r_pend;
  logic [IW-1:0] w_own, r_own;
  logic          err_b, err_r;
  logic          w_busy, r_busy, wr_ok, rd_ok, aw_take, ar_take;
  logic          err_w_go, err_r_go;

  split_addr_decode #(.N_PORT(N_PORT), .ADDR_W(ADDR_W), .IW(IW),
                      .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2))
    u_aw_dec (.addr(s_awaddr), .hit(aw_hit), .idx(aw_idx), .offset(aw_off));

  split_addr_decode #(.N_PORT(N_PORT), .ADDR_W(ADDR_W), .IW(IW),
                      .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2))
    u_ar_dec (.addr(s_araddr), .hit(ar_hit), .idx(ar_idx), .offset(ar_off));

  // Write channel acceptance
  assign w_busy   = w_pend | err_b;
  assign wr_ok    = s_awvalid & s_wvalid & (|aw_hit) & ~w_busy;
  assign aw_take  = m_awready[aw_idx] & m_wready[aw_idx];
  assign err_w_go = ~w_busy & s_awvalid & (~s_wvalid | ~(|aw_hit));
  assign s_awready = (wr_ok & aw_take) | (~w_busy & s_awvalid & s_wvalid & ~(|aw_hit));
  assign s_wready  = s_awready;

  // Read channel acceptance
  assign r_busy   = r_pend | err_r;
  assign rd_ok    = s_arvalid & (|ar_hit) & ~r_busy;
  assign ar_take  = m_arready[ar_idx];
  assign err_r_go = ~r_busy & s_arvalid & ~(|ar_hit);
  assign s_arready = (rd_ok & ar_take) | err_r_go;

  for (genvar g = 0; g < N_PORT; g++) begin : g_port
    assign m_awvalid[g] = wr_ok & aw_hit[g];
    assign m_wvalid[g]  = wr_ok & aw_hit[g];
    assign m_awaddr[g*ADDR_W +: ADDR_W] = aw_off[g*ADDR_W +: ADDR_W];
    assign m_wdata[g*DATA_W +: DATA_W]  = s_wdata;
    assign m_wstrb[g*STRB_W +: STRB_W]  = s_wstrb;
    assign m_bready[g]  = w_pend & (w_own == IW'(g)) & s_bready;
    assign m_arvalid[g] = rd_ok & ar_hit[g];
    assign m_araddr[g*ADDR_W +: ADDR_W] = ar_off[g*ADDR_W +: ADDR_W];
    assign m_rready[g]  = r_pend & (r_own == IW'(g)) & s_rready;
  end

  // Response return from the owning port or the local error path
  assign s_bvalid = err_b | (w_pend & m_bvalid[w_own]);
  assign s_bresp  = err_b ? RESP_SLVERR : m_bresp[int'(w_own)*2 +: 2];
  assign s_rvalid = err_r | (r_pend & m_rvalid[r_own]);
  assign s_rdata  = err_r ? '0 : m_rdata[int'(r_own)*DATA_W +: DATA_W];
  assign s_rresp  = err_r ? RESP_SLVERR : m_rresp[int'(r_own)*2 +: 2];

  always_ff @(posedge clk) begin
    if (rst) begin
      w_pend <= 1'b0;
      w_own  <= '0;
      r_pend <= 1'b0;
      r_own  <= '0;
    end else begin
      if (wr_ok & aw_take) begin
        w_pend <= 1'b1;
        w_own  <= aw_idx;
      end else if (w_pend & m_bvalid[w_own] & s_bready) begin
        w_pend <= 1'b0;
      end
      if (rd_ok & ar_take) begin
        r_pend <= 1'b1;
        r_own  <= ar_idx;
      end else if (r_pend & m_rvalid[r_own] & s_rready) begin
        r_pend <= 1'b0;
      end
    end
  end

  split_err_resp u_err_b (.clk(clk), .rst(rst), .start(err_w_go), .ready(s_bready), .valid(err_b));
  split_err_resp u_err_r (.clk(clk), .rst(rst), .start(err_r_go), .ready(s_rready), .valid(err_r));

  AST_ONE_AW: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_awvalid)); // R1
  AST_ONE_AR: assert property (@(posedge clk) disable iff (rst)
    $onehot0(m_arvalid)); // R1
  AST_WR_PAIR: assert property (@(posedge clk) disable iff (rst)
    s_awready |-> s_awvalid && s_wvalid && s_wready); // R2
  AST_LONE_AW: assert property (@(posedge clk) disable iff (rst)
    s_awvalid && !s_wvalid |-> m_awvalid == '0 && m_wvalid == '0 && !s_awready); // R3
  AST_UNMAPPED_RD: assert property (@(posedge clk) disable iff (rst)
    s_arvalid && ar_hit == '0 |-> m_arvalid == '0); // R4
  AST_UNMAPPED_WR: assert property (@(posedge clk) disable iff (rst)
    s_awvalid && aw_hit == '0 && !s_bvalid && !w_pend |=> s_bvalid && s_bresp == RESP_SLVERR); // R5
  AST_BUSY_NO_FWD: assert property (@(posedge clk) disable iff (rst)
    s_bvalid |-> m_awvalid == '0); // R10
endmodule

// File: tb/test_axil_window_split.sv
`timescale 1ns/1ps
module test_axil_window_split;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk; // 50 MHz

  logic        awv = 0, wv = 0, bready = 0, arv = 0, rready = 0;
  logic [15:0] awaddr = 0, araddr = 0;
  logic [31:0] wdata = 0;
  logic [3:0]  wstrb = 0;
  logic [2:0]  d_awrdy = 0, d_wrdy = 0, d_bv = 0, d_arrdy = 0, d_rv = 0;
  logic [5:0]  d_bresp = 0, d_rresp = 0;
  logic [95:0] d_rdata = 0;

  logic        s_awready, s_wready, s_bvalid, s_arready, s_rvalid;
  logic [1:0]  s_bresp, s_rresp;
  logic [31:0] s_rdata;
  logic [2:0]  m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic [47:0] m_awaddr, m_araddr;
  logic [95:0] m_wdata;
  logic [11:0] m_wstrb;

  axil_window_split i_axil_window_split (
    .clk(clk), .rst(rst),
    .s_awvalid(awv), .s_awaddr(awaddr), .s_awready(s_awready),
    .s_wvalid(wv), .s_wdata(wdata), .s_wstrb(wstrb), .s_wready(s_wready),
    .s_bvalid(s_bvalid), .s_bresp(s_bresp), .s_bready(bready),
    .s_arvalid(arv), .s_araddr(araddr), .s_arready(s_arready),
    .s_rvalid(s_rvalid), .s_rdata(s_rdata), .s_rresp(s_rresp), .s_rready(rready),
    .m_awvalid(m_awvalid), .m_awaddr(m_awaddr), .m_awready(d_awrdy),
    .m_wvalid(m_wvalid), .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wready(d_wrdy),
    .m_bvalid(d_bv), .m_bresp(d_bresp), .m_bready(m_bready),
    .m_arvalid(m_arvalid), .m_araddr(m_araddr), .m_arready(d_arrdy),
    .m_rvalid(d_rv), .m_rdata(d_rdata), .m_rresp(d_rresp), .m_rready(m_rready)
  );

  int nchk = 0, nfail = 0;
  int wbase[3] = '{32'h0000, 32'h1000, 32'h4000};
  int wsize[3] = '{32'h1000, 32'h1000, 32'h2000};

  // behavioural model state
  bit mb_err = 0, mr_err = 0, mw_pend = 0, mr_pend = 0;
  int mw_own = 0, mr_own = 0;

  function automatic int dec(logic [15:0] a);
    for (int i = 0; i < 3; i++)
      if (int'(a) >= wbase[i] && int'(a) < wbase[i] + wsize[i]) return i;
    return -1;
  endfunction

  task automatic chk(string tag, string what, logic [31:0] got, logic [31:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s %s got %h exp %h", tag, what, got, exp);
    end
  endtask

  task automatic tick(string tag);
    int  ai, ri;
    bit  wb, rb, wok, rok, awr, arr, wgo, rgo;
    logic [2:0] e_awv, e_arv;
    ai = dec(awaddr);
    ri = dec(araddr);
    wb  = mw_pend || mb_err;
    rb  = mr_pend || mr_err;
    wok = awv && wv && ai >= 0 && !wb;
    rok = arv && ri >= 0 && !rb;
    awr = wok ? (d_awrdy[ai] && d_wrdy[ai]) : (!wb && awv && wv && ai < 0);
    arr = rok ? d_arrdy[ri] : (!rb && arv && ri < 0);
    wgo = !wb && awv && (!wv || ai < 0);
    rgo = !rb && arv && ri < 0;
    e_awv = wok ? (3'b001 << ai) : 3'b000;
    e_arv = rok ? (3'b001 << ri) : 3'b000;
    #2;
    chk(tag, "R1 m_awvalid", 32'(m_awvalid), 32'(e_awv));
    chk(tag, "R1 m_wvalid",  32'(m_wvalid),  32'(e_awv));
    chk(tag, "R1 m_arvalid", 32'(m_arvalid), 32'(e_arv));
    chk(tag, "R2 s_awready", 32'(s_awready), 32'(awr));
    chk(tag, "R2 s_wready",  32'(s_wready),  32'(awr));
    chk(tag, "R7 s_bvalid",  32'(s_bvalid),  32'(mb_err || (mw_pend && d_bv[mw_own])));
    chk(tag, "R7 s_bresp",   32'(s_bresp),   mb_err ? 32'd2 : 32'(d_bresp[mw_own*2 +: 2]));
    chk(tag, "R7 m_bready",  32'(m_bready),  mw_pend ? 32'(32'(bready) << mw_own) : 32'd0);
    chk(tag, "R8 s_arready", 32'(s_arready), 32'(arr));
    chk(tag, "R8 s_rvalid",  32'(s_rvalid),  32'(mr_err || (mr_pend && d_rv[mr_own])));
    chk(tag, "R8 s_rdata",   s_rdata,        mr_err ? 32'd0 : d_rdata[mr_own*32 +: 32]);
    chk(tag, "R8 s_rresp",   32'(s_rresp),   mr_err ? 32'd2 : 32'(d_rresp[mr_own*2 +: 2]));
    chk(tag, "R8 m_rready",  32'(m_rready),  mr_pend ? 32'(32'(rready) << mr_own) : 32'd0);
    if (wok) begin
      chk(tag, "R9 m_awaddr", 32'(m_awaddr[ai*16 +: 16]), 32'(int'(awaddr) - wbase[ai]));
      chk(tag, "R6 m_wdata",  m_wdata[ai*32 +: 32], wdata);
      chk(tag, "R6 m_wstrb",  32'(m_wstrb[ai*4 +: 4]), 32'(wstrb));
    end
    if (rok) chk(tag, "R9 m_araddr", 32'(m_araddr[ri*16 +: 16]), 32'(int'(araddr) - wbase[ri]));
    @(posedge clk);
    if (rst) begin
      mb_err = 0; mr_err = 0; mw_pend = 0; mr_pend = 0; mw_own = 0; mr_own = 0;
    end else begin
      if (wgo) mb_err = 1; else if (mb_err && bready) mb_err = 0;
      if (rgo) mr_err = 1; else if (mr_err && rready) mr_err = 0;
      if (wok && awr) begin mw_pend = 1; mw_own = ai; end
      else if (mw_pend && d_bv[mw_own] && bready) mw_pend = 0;
      if (rok && arr) begin mr_pend = 1; mr_own = ri; end
      else if (mr_pend && d_rv[mr_own] && rready) mr_pend = 0;
    end
    @(negedge clk);
  endtask

  task automatic wr(logic [15:0] a, logic [31:0] d, logic [3:0] s);
    awv = 1; wv = 1; awaddr = a; wdata = d; wstrb = s;
  endtask

  initial begin
    @(negedge clk);
    tick("R11"); tick("R11");
    rst = 0;
    tick("R11");
    d_awrdy = 3'b111; d_wrdy = 3'b111; d_arrdy = 3'b111;

    // mapped write to port 1, response held then taken
    wr(16'h1234, 32'hCAFE_0001, 4'hF); tick("R2");
    awv = 0; wv = 0; tick("R7");
    d_bv = 3'b010; d_bresp = 6'b00_00_00; tick("R7");
    bready = 1; tick("R7");
    d_bv = 0; bready = 0; tick("R7");

    // port 2 with a one-cycle write-ready stall, boundary address
    d_wrdy = 3'b011;
    wr(16'h5FFF, 32'h1234_5678, 4'h5); tick("R2");
    d_wrdy = 3'b111; tick("R9");
    awv = 0; wv = 0; d_bv = 3'b100; d_bresp = 6'b01_00_00; bready = 1; tick("R7");
    d_bv = 0; bready = 0; tick("R7");

    // mapped read to port 0 with arready stall
    d_arrdy = 3'b110; arv = 1; araddr = 16'h0ABC; tick("R8");
    d_arrdy = 3'b111; tick("R8");
    arv = 0; d_rv = 3'b001; d_rdata[31:0] = 32'hDEAD_BEEF; d_rresp = 6'b00_00_01; tick("R8");
    rready = 1; tick("R8");
    d_rv = 0; rready = 0; tick("R8");

    // unmapped read, error held two cycles
    arv = 1; araddr = 16'h2222; tick("R4");
    arv = 0; tick("R4"); tick("R10");
    rready = 1; tick("R10");
    rready = 0; tick("R10");

    // unmapped write
    wr(16'h7000, 32'hA5A5_5A5A, 4'hF); tick("R5");
    awv = 0; wv = 0; bready = 1; tick("R5");
    bready = 0; tick("R5");

    // lone write address, then a mapped write offered while the error is pending
    awv = 1; awaddr = 16'h1000; tick("R3");
    awv = 0; tick("R3");
    wr(16'h0010, 32'h0BAD_F00D, 4'h3); tick("R10");
    bready = 1; tick("R10");
    bready = 0; tick("R10");
    awv = 0; wv = 0; tick("R10");
    d_bv = 3'b001; bready = 1; tick("R7");
    d_bv = 0; bready = 0; tick("R7");

    // simultaneous read and write to different ports at window edges
    wr(16'h1FFF, 32'h7777_0000, 4'h8); arv = 1; araddr = 16'h4000; tick("R1");
    awv = 0; wv = 0; arv = 0; tick("R1");
    d_bv = 3'b010; d_rv = 3'b100; d_rdata[95:64] = 32'h0102_0304;
    bready = 1; rready = 1; tick("R8");
    d_bv = 0; d_rv = 0; bready = 0; rready = 0; tick("R8");

    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    #(20 * 200000);
    nchk++; nfail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule